// File: doc/BRIEF.md
# Dual Interval Timer Pair

This block holds two 16-bit down-counters, called A and B, that share an 8-bit register bus. Software programs each timer in two steps. It first writes a reload value into a latch that cannot be read back. It then writes a control byte that starts the count, selects continuous or one-shot operation, and can force the latch into the counter at once. A read from a timer's byte addresses returns the live count, not the latch.

Each timer emits a one-cycle underflow pulse for an interrupt controller. Each can also drive a port pin, either with that pulse or with a level that flips at every underflow. Timer A counts either clock cycles or rising edges of the external count input. Timer B can count clock cycles, count-input edges, Timer A underflows, or Timer A underflows that arrive while the count input is high. Chaining B to A in this way gives a 32-bit interval.

Top module: `twin_timer_top`

## Requirements
- R1: A write to address 4 or 5 (Timer A) or 6 or 7 (Timer B) stores the low or high byte of that timer's reload latch. A read from the same address returns the corresponding byte of the live counter, and the latch value is never visible there.
- R2: Address 0xE holds Timer A's control byte and 0xF holds Timer B's control byte. A read returns the byte last written, except that bit 4 always reads 0. A read from any address other than 4 to 7, 0xE or 0xF returns 0.
- R3: Writing a control byte with bit 4 set copies the latch into that timer's counter at the write edge. The timer does not count in that cycle.
- R4: While control bit 0 is 1, each count event lowers the counter by one. An event that finds the counter at 0 reloads it from the latch and raises that timer's underflow output for the next cycle. A latch value of 0 therefore gives an underflow on every event.
- R5: With control bit 3 set, an underflow clears control bit 0, so the timer stops after reloading.
- R6: For Timer A, control bit 5 = 0 counts every clock and bit 5 = 1 counts rising edges of the count input.
- R7: For Timer B, control bits 6:5 select the count source: 00 every clock, 01 count-input rising edges, 10 Timer A underflows, 11 Timer A underflows while the synchronised count input is high.
- R8: Control bit 1 routes the timer to its pin output; when bit 1 is 0 the pin is 0. Bit 2 = 0 drives the pin with the underflow pulse. Bit 2 = 1 drives it with a level that flips at each underflow and returns to 0 whenever a write sets bit 0 while it was 0.
- R9: After reset both latches and both counters hold 0xFFFF, both control bytes read 0, and all outputs are 0.
- R10: The count input passes through two synchroniser flops. A rise is counted at the third clock edge after it is applied, and a level held high counts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational from state |
| cntIn | input | 1 | External count input, asynchronous |
| underflowA | output | 1 | One-cycle underflow pulse of Timer A |
| underflowB | output | 1 | One-cycle underflow pulse of Timer B |
| pinA | output | 1 | Port pin driven by Timer A |
| pinB | output | 1 | Port pin driven by Timer B |

## Verification
A write is taken at the clock edge where busWrEn is high. A forced load shows on busRdData in the half cycle that follows that edge, and every later count shows on busRdData right after its own edge. An underflow pulse and a pulse-mode pin follow one edge after the event that found the counter at 0, and a count-input rise takes effect at the third edge. A behavioural model in the bench advances on each rising edge with the same inputs the design samples. The bench compares read data, pulses and pins against that model on every falling edge, and the directed probes change the address only after that comparison.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

  // Register addresses on the byte bus
  localparam logic [3:0] ADDR_A_LO = 4'h4;
  localparam logic [3:0] ADDR_A_HI = 4'h5;
  localparam logic [3:0] ADDR_B_LO = 4'h6;
  localparam logic [3:0] ADDR_B_HI = 4'h7;
  localparam logic [3:0] ADDR_CTL_A = 4'hE;
  localparam logic [3:0] ADDR_CTL_B = 4'hF;

  // Control byte bit positions
  localparam int CB_RUN     = 0;
  localparam int CB_ROUTE   = 1;
  localparam int CB_TOGGLE  = 2;
  localparam int CB_ONESHOT = 3;
  localparam int CB_LOAD    = 4;
  localparam int CB_SRC0    = 5;
  localparam int CB_SRC1    = 6;

  // Timer B source codes (bits 6:5)
  localparam logic [1:0] SRC_CLK      = 2'b00;
  localparam logic [1:0] SRC_CNT      = 2'b01;
  localparam logic [1:0] SRC_CHAIN    = 2'b10;
  localparam logic [1:0] SRC_CHAINCNT = 2'b11;

  // Strobes from control to one timer datapath
  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic forceLoad;
    logic countEvt;
    logic startClr;
    logic routeEn;
    logic toggleMode;
  } tmrStrobe_t;

endpackage

// File: rtl/twin_timer_dpath.sv
module twin_timer_dpath
  import twin_timer_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tmrStrobe_t           strb,
  input  logic [BUS_W-1:0]     wrData,
  output logic [2*BUS_W-1:0]   count,
  output logic                 uflNow,
  output logic                 uflPulse,
  output logic                 pinOut
);

  localparam int LANES = 2;
  localparam int CNT_W = LANES * BUS_W;

  logic [BUS_W-1:0] latchLane [LANES];
  logic [CNT_W-1:0] latchVal;
  logic [LANES-1:0] laneWr;
  logic             toggleQ;

  assign laneWr = {strb.wrHi, strb.wrLo};

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              latchLane[lane] <= '1;
      else if (laneWr[lane])  latchLane[lane] <= wrData;
    end
    assign latchVal[lane*BUS_W +: BUS_W] = latchLane[lane];
  end

  assign uflNow = strb.countEvt && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '1;
    end else if (strb.forceLoad) begin
      count <= latchVal;
    end else if (strb.countEvt) begin
      count <= (count == '0) ? latchVal : count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uflPulse <= 1'b0;
      toggleQ  <= 1'b0;
    end else begin
      uflPulse <= uflNow;
      if (strb.startClr)  toggleQ <= 1'b0;
      else if (uflNow)    toggleQ <= ~toggleQ;
    end
  end

  assign pinOut = strb.routeEn && (strb.toggleMode ? toggleQ : uflPulse);

  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceLoad |=> count == $past(latchVal)); // R3

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (uflNow && !strb.forceLoad) |=> (count == $past(latchVal) && uflPulse)); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEvt && !strb.forceLoad && count != '0) |=> count == $past(count) - 1'b1); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEvt && !strb.forceLoad) |=> $stable(count)); // R4

endmodule

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       busAddr,
  input  logic             busWrEn,
  input  logic [BUS_W-1:0] busWrData,
  input  logic             cntIn,
  input  logic             uflNowA,
  input  logic             uflNowB,
  output tmrStrobe_t       strbA,
  output tmrStrobe_t       strbB,
  output logic [BUS_W-1:0] ctlA,
  output logic [BUS_W-1:0] ctlB
);

  localparam logic [BUS_W-1:0] LOAD_MASK = ~(BUS_W'(1) << CB_LOAD);

  // synchroniser stages followed by one edge-history flop
  logic [SYNC_STAGES:0] cntPipe;
  logic cntLevel, cntRise;
  logic wrCtlA, wrCtlB, forceA, forceB;
  logic evA, evB;
  logic [1:0] srcB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntPipe <= '0;
    else       cntPipe <= {cntPipe[SYNC_STAGES-1:0], cntIn};
  end

  assign cntLevel = cntPipe[SYNC_STAGES-1];
  assign cntRise  = cntLevel && !cntPipe[SYNC_STAGES];

  assign wrCtlA = busWrEn && (busAddr == ADDR_CTL_A);
  assign wrCtlB = busWrEn && (busAddr == ADDR_CTL_B);
  assign forceA = wrCtlA && busWrData[CB_LOAD];
  assign forceB = wrCtlB && busWrData[CB_LOAD];
  assign srcB   = ctlB[CB_SRC1:CB_SRC0];

  always_comb begin
    evA = ctlA[CB_RUN] && (ctlA[CB_SRC0] ? cntRise : 1'b1);
    strbA.wrLo       = busWrEn && (busAddr == ADDR_A_LO);
    strbA.wrHi       = busWrEn && (busAddr == ADDR_A_HI);
    strbA.forceLoad  = forceA;
    strbA.countEvt   = evA && !forceA;
    strbA.startClr   = wrCtlA && busWrData[CB_RUN] && !ctlA[CB_RUN];
    strbA.routeEn    = ctlA[CB_ROUTE];
    strbA.toggleMode = ctlA[CB_TOGGLE];
  end

  always_comb begin
    unique case (srcB)
      SRC_CLK:      evB = 1'b1;
      SRC_CNT:      evB = cntRise;
      SRC_CHAIN:    evB = uflNowA;
      SRC_CHAINCNT: evB = uflNowA && cntLevel;
      default:      evB = 1'b0;
    endcase
    evB = evB && ctlB[CB_RUN];
    strbB.wrLo       = busWrEn && (busAddr == ADDR_B_LO);
    strbB.wrHi       = busWrEn && (busAddr == ADDR_B_HI);
    strbB.forceLoad  = forceB;
    strbB.countEvt   = evB && !forceB;
    strbB.startClr   = wrCtlB && busWrData[CB_RUN] && !ctlB[CB_RUN];
    strbB.routeEn    = ctlB[CB_ROUTE];
    strbB.toggleMode = ctlB[CB_TOGGLE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlA <= '0;
      ctlB <= '0;
    end else begin
      if (wrCtlA)                            ctlA <= busWrData & LOAD_MASK;
      else if (uflNowA && ctlA[CB_ONESHOT])  ctlA[CB_RUN] <= 1'b0;
      if (wrCtlB)                            ctlB <= busWrData & LOAD_MASK;
      else if (uflNowB && ctlB[CB_ONESHOT])  ctlB[CB_RUN] <= 1'b0;
    end
  end

  AST_ONESHOT_STOP_A: assert property (@(posedge clk) disable iff (!rstN)
    (uflNowA && ctlA[CB_ONESHOT] && !wrCtlA) |=> !ctlA[CB_RUN]); // R5

  AST_ONESHOT_STOP_B: assert property (@(posedge clk) disable iff (!rstN)
    (uflNowB && ctlB[CB_ONESHOT] && !wrCtlB) |=> !ctlB[CB_RUN]); // R5

endmodule

// File: rtl/twin_timer_top.sv
module twin_timer_top
  import twin_timer_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       busAddr,
  input  logic             busWrEn,
  input  logic [BUS_W-1:0] busWrData,
  output logic [BUS_W-1:0] busRdData,
  input  logic             cntIn,
  output logic             underflowA,
  output logic             underflowB,
  output logic             pinA,
  output logic             pinB
);

  localparam int CNT_W = 2 * BUS_W;

  tmrStrobe_t       strbA, strbB;
  logic [BUS_W-1:0] ctlA, ctlB;
  logic [CNT_W-1:0] countA, countB;
  logic             uflNowA, uflNowB;

  twin_timer_ctrl #(.BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .cntIn(cntIn), .uflNowA(uflNowA), .uflNowB(uflNowB),
    .strbA(strbA), .strbB(strbB), .ctlA(ctlA), .ctlB(ctlB)
  );

  twin_timer_dpath #(.BUS_W(BUS_W)) u_dpathA (
    .clk(clk), .rstN(rstN), .strb(strbA), .wrData(busWrData),
    .count(countA), .uflNow(uflNowA), .uflPulse(underflowA), .pinOut(pinA)
  );

  twin_timer_dpath #(.BUS_W(BUS_W)) u_dpathB (
    .clk(clk), .rstN(rstN), .strb(strbB), .wrData(busWrData),
    .count(countB), .uflNow(uflNowB), .uflPulse(underflowB), .pinOut(pinB)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_A_LO:  busRdData = countA[BUS_W-1:0];
      ADDR_A_HI:  busRdData = countA[CNT_W-1:BUS_W];
      ADDR_B_LO:  busRdData = countB[BUS_W-1:0];
      ADDR_B_HI:  busRdData = countB[CNT_W-1:BUS_W];
      ADDR_CTL_A: busRdData = ctlA;
      ADDR_CTL_B: busRdData = ctlB;
      default:    busRdData = '0;
    endcase
  end

  AST_CHAIN_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (uflNowA && ctlB[CB_RUN] && ctlB[CB_SRC1:CB_SRC0] == SRC_CHAIN && countB == '0
     && !(busWrEn && busAddr == ADDR_CTL_B && busWrData[CB_LOAD])) |=> underflowB); // R7

endmodule

// File: tb/twin_timer_top_tb.sv
`timescale 1ns/1ps
module twin_timer_top_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic       cntIn = 1'b0;
  logic [7:0] busRdData;
  logic       underflowA, underflowB, pinA, pinB;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int mLat[2], mCnt[2], mCtl[2], mTog[2], mUfl[2];
  int s0, s1, pv;
  int rise, lvl, fA, fB, eA, eB, uA, uB, sel;

  twin_timer_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .cntIn(cntIn),
    .underflowA(underflowA), .underflowB(underflowB), .pinA(pinA), .pinB(pinB)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRead(input int a);
    case (a)
      4:  return mCnt[0] & 8'hFF;
      5:  return (mCnt[0] >> 8) & 8'hFF;
      6:  return mCnt[1] & 8'hFF;
      7:  return (mCnt[1] >> 8) & 8'hFF;
      14: return mCtl[0];
      15: return mCtl[1];
      default: return 0;
    endcase
  endfunction

  function automatic int expPin(input int t);
    if (((mCtl[t] >> 1) & 1) == 0) return 0;
    return ((mCtl[t] >> 2) & 1) ? mTog[t] : mUfl[t];
  endfunction

  // reference model: one step per rising edge, inputs as sampled by the design
  always @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < 2; t++) begin
        mLat[t] = 16'hFFFF; mCnt[t] = 16'hFFFF; mCtl[t] = 0; mTog[t] = 0; mUfl[t] = 0;
      end
      s0 = 0; s1 = 0; pv = 0;
    end else begin
      rise = (s1 == 1 && pv == 0) ? 1 : 0;
      lvl  = s1;
      pv = s1; s1 = s0; s0 = cntIn;
      fA = (busWrEn && busAddr == 4'hE && busWrData[4]) ? 1 : 0;
      fB = (busWrEn && busAddr == 4'hF && busWrData[4]) ? 1 : 0;
      eA = ((mCtl[0] & 1) && (((mCtl[0] >> 5) & 1) ? rise : 1) && !fA) ? 1 : 0;
      uA = (eA && mCnt[0] == 0) ? 1 : 0;
      sel = (mCtl[1] >> 5) & 3;
      eB = ((mCtl[1] & 1) && !fB && (sel == 0 || (sel == 1 && rise) ||
            (sel == 2 && uA) || (sel == 3 && uA && lvl))) ? 1 : 0;
      uB = (eB && mCnt[1] == 0) ? 1 : 0;
      if (fA) mCnt[0] = mLat[0];
      else if (eA) mCnt[0] = (mCnt[0] == 0) ? mLat[0] : mCnt[0] - 1;
      if (fB) mCnt[1] = mLat[1];
      else if (eB) mCnt[1] = (mCnt[1] == 0) ? mLat[1] : mCnt[1] - 1;
      if (uA) mTog[0] = 1 - mTog[0];
      if (uB) mTog[1] = 1 - mTog[1];
      if (busWrEn && busAddr == 4'hE) begin
        if (busWrData[0] && !(mCtl[0] & 1)) mTog[0] = 0;
        mCtl[0] = busWrData & 8'hEF;
      end else if (uA && ((mCtl[0] >> 3) & 1)) mCtl[0] = mCtl[0] & 8'hFE;
      if (busWrEn && busAddr == 4'hF) begin
        if (busWrData[0] && !(mCtl[1] & 1)) mTog[1] = 0;
        mCtl[1] = busWrData & 8'hEF;
      end else if (uB && ((mCtl[1] >> 3) & 1)) mCtl[1] = mCtl[1] & 8'hFE;
      mUfl[0] = uA; mUfl[1] = uB;
      if (busWrEn) begin
        case (busAddr)
          4'h4: mLat[0] = (mLat[0] & 16'hFF00) | busWrData;
          4'h5: mLat[0] = (mLat[0] & 16'h00FF) | (busWrData << 8);
          4'h6: mLat[1] = (mLat[1] & 16'hFF00) | busWrData;
          4'h7: mLat[1] = (mLat[1] & 16'h00FF) | (busWrData << 8);
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      chk((busAddr >= 4 && busAddr <= 7) ? "R1 read" : "R2 read", busRdData, expRead(busAddr));
      chk("R4 underflowA", underflowA, mUfl[0]);
      chk("R7 underflowB", underflowB, mUfl[1]);
      chk("R8 pinA", pinA, expPin(0));
      chk("R8 pinB", pinB, expPin(1));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic peek(input string tag, input logic [3:0] a, input int exp);
    @(negedge clk); #2;
    busAddr = a; #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cntPulse(input int hi, input int lo);
    @(posedge clk); #1 cntIn = 1'b1;
    repeat (hi) @(posedge clk);
    #1 cntIn = 1'b0;
    repeat (lo) @(posedge clk);
    #1;
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9: reset values
    peek("R9 countA lo", 4'h4, 8'hFF);
    peek("R9 countB hi", 4'h7, 8'hFF);
    peek("R9 ctlA", 4'hE, 8'h00);
    chk("R9 outputs", {underflowA, underflowB, pinA, pinB}, 0);
    peek("R2 unmapped", 4'h9, 8'h00);

    // R1: latch writes do not show on the read path
    wr(4'h4, 8'h05);
    wr(4'h5, 8'h00);
    peek("R1 latch hidden", 4'h4, 8'hFF);

    // R3: forced load, strobe reads back as 0
    wr(4'hE, 8'h11);
    peek("R3 forced load", 4'h4, 8'h05);
    peek("R3 strobe reads 0", 4'hE, 8'h01);
    busAddr = 4'h4;
    idle(20);

    // R5: one-shot stops after the reload
    wr(4'h4, 8'h03);
    wr(4'hE, 8'h19);
    busAddr = 4'h4;
    idle(12);
    peek("R5 run cleared", 4'hE, 8'h08);
    peek("R5 counter reloaded", 4'h4, 8'h03);

    // R8: toggle then pulse pin modes
    wr(4'h4, 8'h02);
    wr(4'hE, 8'h17);
    busAddr = 4'h4;
    idle(12);
    wr(4'hE, 8'h13);
    idle(10);
    wr(4'hE, 8'h15);
    idle(6);

    // R4: zero latch underflows on every event
    wr(4'h4, 8'h00);
    wr(4'hE, 8'h11);
    idle(4);
    chk("R4 zero latch", underflowA, 1);

    // R7: B counts A underflows
    wr(4'h4, 8'h01);
    wr(4'h6, 8'h02);
    wr(4'h7, 8'h00);
    wr(4'hE, 8'h11);
    wr(4'hF, 8'h53);
    busAddr = 4'h6;
    idle(24);

    // R6, R10: A counts count-input edges
    wr(4'hF, 8'h00);
    wr(4'h4, 8'h0A);
    wr(4'hE, 8'h31);
    busAddr = 4'h4;
    for (int k = 0; k < 3; k++) cntPulse(2, 2);
    idle(5);
    peek("R6 three edges", 4'h4, 8'h07);
    cntPulse(8, 4);
    peek("R10 level counts once", 4'h4, 8'h06);

    // R7: B on count-input edges
    wr(4'hE, 8'h00);
    wr(4'h6, 8'h04);
    wr(4'hF, 8'h31);
    busAddr = 4'h6;
    cntPulse(2, 2);
    cntPulse(2, 2);
    idle(4);
    peek("R7 edge source", 4'h6, 8'h02);

    // R7: B on A underflows gated by count-input level
    wr(4'h4, 8'h00);
    wr(4'hE, 8'h11);
    wr(4'h6, 8'h09);
    wr(4'hF, 8'h71);
    busAddr = 4'h6;
    idle(4);
    cntPulse(6, 6);
    cntPulse(3, 4);
    idle(4);

    finishRun();
  end

endmodule